// File: doc/BRIEF.md
# Overlap-Safe Blit Setup Unit

This block prepares a rectangle copy for a blitter. It takes a source corner, a destination corner, a width and a height, and it chooses a scan direction for each axis so that a copy between overlapping areas never reads a pixel that the same copy has already overwritten. When an axis is scanned backwards, both corners move to the far edge along that axis. In packed 24-bit pixel mode the engine works in byte units. In that mode every horizontal quantity is tripled and a byte-rotation phase is derived for the engine.

A request arrives over a valid/ready handshake and is taken only while the unit is idle. For one cycle after acceptance the unit presents the adjusted corners, the width in engine units, the direction bits, the rotation code and packed words for the engine. It then walks the destination rectangle and issues one address per engine unit per cycle in the chosen order. It stays busy until the final address has been issued. A request with an empty area is consumed and has no effect.

Top module: `blit_setup`

## Requirements
- R1: A request accepted with width 0 or height 0 produces no `setup_valid` pulse and no walk address, and `req_ready` stays high.
- R2: When `req_mode24` is 1, the source x, destination x and width are multiplied by 3 before any other step, and `unit_width` equals 3×width. When it is 0 they pass through unchanged.
- R3: If source y < destination y, `y_fwd` is 0 and height−1 is added to both y values. Otherwise `y_fwd` is 1 and both y values are unchanged.
- R4: If the scaled source x < the scaled destination x, `x_fwd` is 0 and `unit_width`−1 is added to both scaled x values. Otherwise `x_fwd` is 1 and both scaled x values are unchanged.
- R5: In 24-bit mode `rot_en` is 1 and `rot_code` = (dx/4) mod 6 when `x_fwd` is 1, or ((dx+2)/4) mod 6 when `x_fwd` is 0, where dx is the adjusted destination x. In 8-bit mode `rot_en` and `rot_code` are 0. `rot_code` is never 6 or 7.
- R6: `src_xy_word` = {src x[15:0], src y[15:0]}, `dst_xy_word` = {dst x[15:0], dst y[15:0]}, and `size_word` = {unit_width[15:0], height[15:0]}, all taken from the adjusted values.
- R7: `dir_word` carries bit 0 = `x_fwd`, bit 1 = `y_fwd`, bit 5 = last-pixel flag (always 1), bit 7 = `rot_en`, bits [10:8] = `rot_code`, and 0 in all other bits.
- R8: `req_ready` is high only while idle. `setup_valid` pulses for exactly the one cycle after a non-empty request is accepted. `busy` is high from that cycle through the cycle that carries `walk_last`, and the setup outputs do not change while busy.
- R9: The walk begins at the adjusted destination corner and issues `unit_width`×height addresses on consecutive cycles. x steps by +1 (`x_fwd`=1) or −1 within a row. At the end of a row x returns to the start x and y steps by +1 (`y_fwd`=1) or −1. `walk_last` marks only the final address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_src_x | input | CW | Source x in pixels |
| req_src_y | input | CW | Source y |
| req_dst_x | input | CW | Destination x in pixels |
| req_dst_y | input | CW | Destination y |
| req_width | input | CW | Width in pixels |
| req_height | input | CW | Height in rows |
| req_mode24 | input | 1 | Packed 24-bit pixel mode |
| setup_valid | output | 1 | One-cycle strobe: setup outputs are new |
| src_x_o | output | CW+3 | Adjusted source start x (engine units) |
| src_y_o | output | CW+1 | Adjusted source start y |
| dst_x_o | output | CW+3 | Adjusted destination start x |
| dst_y_o | output | CW+1 | Adjusted destination start y |
| unit_width | output | CW+3 | Width in engine units |
| x_fwd | output | 1 | 1 = left to right |
| y_fwd | output | 1 | 1 = top to bottom |
| rot_code | output | 3 | 24-bit byte-rotation phase |
| rot_en | output | 1 | Rotation enable |
| dir_word | output | 16 | Packed direction control |
| src_xy_word | output | 32 | Packed source coordinate |
| dst_xy_word | output | 32 | Packed destination coordinate |
| size_word | output | 32 | Packed size |
| busy | output | 1 | Walk in progress |
| walk_valid | output | 1 | Walk address present |
| walk_x | output | CW+3 | Walk x |
| walk_y | output | CW+1 | Walk y |
| walk_last | output | 1 | Final walk address |

## Verification
The assertions check the walk step rules on every cycle: x moves by one in the chosen direction within a row, and a row change returns x to its start and moves y by one. They also check on every cycle that a walk ends after its last address, that `setup_valid` never lasts two cycles, that the setup outputs hold still while busy, that empty requests leave no trace and that the rotation code stays in range. The exact arithmetic can only be shown by the bench's sweeps, which cover both modes and every ordering of source and destination on each axis. That arithmetic is the tripling, the far-corner offsets, the rotation phase for both scan directions, the packing, and the length and end points of the walk.

// File: rtl/blit_setup_pkg.sv
package blit_setup_pkg;
  // Bit positions inside the direction control word
  localparam int DIRW_XFWD  = 0;
  localparam int DIRW_YFWD  = 1;
  localparam int DIRW_LAST  = 5;
  localparam int DIRW_ROTEN = 7;
  localparam int DIRW_ROTLO = 8;

  typedef enum logic {WK_IDLE = 1'b0, WK_RUN = 1'b1} walk_st_e;
endpackage

// File: rtl/blit_geom.sv
module blit_geom #(
  parameter int CW = 16,
  localparam int XW = CW + 3,
  localparam int YW = CW + 1
) (
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic          m24,
  output logic [XW-1:0] sx_adj,
  output logic [YW-1:0] sy_adj,
  output logic [XW-1:0] dx_adj,
  output logic [YW-1:0] dy_adj,
  output logic [XW-1:0] wu,
  output logic          xf,
  output logic          yf
);
  logic [XW-1:0] sx_s, dx_s, xoff;
  logic [YW-1:0] yoff;

  // Tripling in 24-bit mode: v*3 = (v<<1) + v
  always_comb begin
    if (m24) begin
      sx_s = (XW'(sx) << 1) + XW'(sx);
      dx_s = (XW'(dx) << 1) + XW'(dx);
      wu   = (XW'(w)  << 1) + XW'(w);
    end else begin
      sx_s = XW'(sx);
      dx_s = XW'(dx);
      wu   = XW'(w);
    end
  end

  always_comb begin
    xoff   = wu - XW'(1);
    yoff   = YW'(h) - YW'(1);
    yf     = !(sy < dy);
    xf     = !(sx_s < dx_s);
    sy_adj = yf ? YW'(sy) : YW'(sy) + yoff;
    dy_adj = yf ? YW'(dy) : YW'(dy) + yoff;
    sx_adj = xf ? sx_s : sx_s + xoff;
    dx_adj = xf ? dx_s : dx_s + xoff;
  end
endmodule

// File: rtl/blit_rot.sv
module blit_rot #(
  parameter int XW = 19
) (
  input  logic [XW-1:0] dx,
  input  logic          xf,
  input  logic          en,
  output logic [2:0]    code
);
  logic [XW-1:0] biased, quarter, phase;

  always_comb begin
    biased  = xf ? dx : dx + XW'(2);
    quarter = biased >> 2;
    phase   = quarter % XW'(6);
    code    = en ? phase[2:0] : 3'd0;
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_setup_pkg::*;
#(
  parameter int CW = 16,
  localparam int XW = CW + 3,
  localparam int YW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic [XW-1:0] wlen,
  input  logic [CW-1:0] hlen,
  input  logic          xf,
  input  logic          yf,
  output logic          active,
  output logic [XW-1:0] wx,
  output logic [YW-1:0] wy,
  output logic          wlast
);
  walk_st_e      st_q, st_d;
  logic [XW-1:0] cx_q, cx_d, xs_q, xs_d, col_q, col_d, wl_q, wl_d;
  logic [YW-1:0] cy_q, cy_d;
  logic [CW-1:0] row_q, row_d, hl_q, hl_d;
  logic          xf_q, xf_d, yf_q, yf_d;
  logic          row_end, at_last;

  assign row_end = (col_q == wl_q - XW'(1));
  assign at_last = row_end && (row_q == hl_q - CW'(1));

  always_comb begin
    st_d  = st_q;
    cx_d  = cx_q;
    cy_d  = cy_q;
    xs_d  = xs_q;
    col_d = col_q;
    row_d = row_q;
    wl_d  = wl_q;
    hl_d  = hl_q;
    xf_d  = xf_q;
    yf_d  = yf_q;
    if (st_q == WK_IDLE) begin
      if (load) begin
        st_d  = WK_RUN;
        cx_d  = x0;
        xs_d  = x0;
        cy_d  = y0;
        col_d = '0;
        row_d = '0;
        wl_d  = wlen;
        hl_d  = hlen;
        xf_d  = xf;
        yf_d  = yf;
      end
    end else if (at_last) begin
      st_d = WK_IDLE;
    end else if (row_end) begin
      col_d = '0;
      row_d = row_q + CW'(1);
      cx_d  = xs_q;
      cy_d  = yf_q ? cy_q + YW'(1) : cy_q - YW'(1);
    end else begin
      col_d = col_q + XW'(1);
      cx_d  = xf_q ? cx_q + XW'(1) : cx_q - XW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      cx_q  <= '0;
      cy_q  <= '0;
      xs_q  <= '0;
      col_q <= '0;
      row_q <= '0;
      wl_q  <= '0;
      hl_q  <= '0;
      xf_q  <= 1'b0;
      yf_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cx_q  <= cx_d;
      cy_q  <= cy_d;
      xs_q  <= xs_d;
      col_q <= col_d;
      row_q <= row_d;
      wl_q  <= wl_d;
      hl_q  <= hl_d;
      xf_q  <= xf_d;
      yf_q  <= yf_d;
    end
  end

  assign active = (st_q == WK_RUN);
  assign wx     = cx_q;
  assign wy     = cy_q;
  assign wlast  = active && at_last;

  AST_WALK_XSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !row_end) |=> (wx == ($past(xf_q) ? $past(wx) + XW'(1) : $past(wx) - XW'(1))) && $stable(wy)); // R9
  AST_WALK_YSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && row_end && !at_last) |=> (wy == ($past(yf_q) ? $past(wy) + YW'(1) : $past(wy) - YW'(1))) && (wx == xs_q)); // R9
  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wlast |=> !active); // R8
endmodule

// File: rtl/blit_setup.sv
module blit_setup
  import blit_setup_pkg::*;
#(
  parameter int CW = 16,
  localparam int XW = CW + 3,
  localparam int YW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_src_x,
  input  logic [CW-1:0] req_src_y,
  input  logic [CW-1:0] req_dst_x,
  input  logic [CW-1:0] req_dst_y,
  input  logic [CW-1:0] req_width,
  input  logic [CW-1:0] req_height,
  input  logic          req_mode24,
  output logic          setup_valid,
  output logic [XW-1:0] src_x_o,
  output logic [YW-1:0] src_y_o,
  output logic [XW-1:0] dst_x_o,
  output logic [YW-1:0] dst_y_o,
  output logic [XW-1:0] unit_width,
  output logic          x_fwd,
  output logic          y_fwd,
  output logic [2:0]    rot_code,
  output logic          rot_en,
  output logic [15:0]   dir_word,
  output logic [31:0]   src_xy_word,
  output logic [31:0]   dst_xy_word,
  output logic [31:0]   size_word,
  output logic          busy,
  output logic          walk_valid,
  output logic [XW-1:0] walk_x,
  output logic [YW-1:0] walk_y,
  output logic          walk_last
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [XW-1:0] g_sx, g_dx, g_wu;
  logic [YW-1:0] g_sy, g_dy;
  logic          g_xf, g_yf;
  logic [2:0]    g_rot;
  logic          take, nonempty, walk_act;

  blit_geom #(.CW(CW)) u_geom (
    .sx(req_src_x), .sy(req_src_y), .dx(req_dst_x), .dy(req_dst_y),
    .w(req_width), .h(req_height), .m24(req_mode24),
    .sx_adj(g_sx), .sy_adj(g_sy), .dx_adj(g_dx), .dy_adj(g_dy),
    .wu(g_wu), .xf(g_xf), .yf(g_yf)
  );

  blit_rot #(.XW(XW)) u_rot (
    .dx(g_dx), .xf(g_xf), .en(req_mode24), .code(g_rot)
  );

  assign req_ready = !walk_act;
  assign nonempty  = (req_width != '0) && (req_height != '0);
  assign take      = req_valid && req_ready && nonempty;

  // Setup result registers, clock enable = take
  logic [XW-1:0] sx_q, dx_q, wu_q;
  logic [YW-1:0] sy_q, dy_q;
  logic [CW-1:0] h_q;
  logic          xf_q, yf_q, en_q, sv_q, sv_d;
  logic [2:0]    rot_q;

  assign sv_d = take;

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      sv_q <= 1'b0;
    end else begin
      sv_q <= sv_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      sx_q  <= '0;
      dx_q  <= '0;
      wu_q  <= '0;
      sy_q  <= '0;
      dy_q  <= '0;
      h_q   <= '0;
      xf_q  <= 1'b0;
      yf_q  <= 1'b0;
      en_q  <= 1'b0;
      rot_q <= '0;
    end else if (take) begin
      sx_q  <= g_sx;
      dx_q  <= g_dx;
      wu_q  <= g_wu;
      sy_q  <= g_sy;
      dy_q  <= g_dy;
      h_q   <= req_height;
      xf_q  <= g_xf;
      yf_q  <= g_yf;
      en_q  <= req_mode24;
      rot_q <= g_rot;
    end
  end

  blit_walker #(.CW(CW)) u_walk (
    .clk(clk), .rst_n(rs_n), .load(take),
    .x0(g_dx), .y0(g_dy), .wlen(g_wu), .hlen(req_height),
    .xf(g_xf), .yf(g_yf),
    .active(walk_act), .wx(walk_x), .wy(walk_y), .wlast(walk_last)
  );

  always_comb begin
    dir_word                          = '0;
    dir_word[DIRW_XFWD]               = xf_q;
    dir_word[DIRW_YFWD]               = yf_q;
    dir_word[DIRW_LAST]               = 1'b1;
    dir_word[DIRW_ROTEN]              = en_q;
    dir_word[DIRW_ROTLO+2:DIRW_ROTLO] = rot_q;
  end

  assign setup_valid = sv_q;
  assign src_x_o     = sx_q;
  assign src_y_o     = sy_q;
  assign dst_x_o     = dx_q;
  assign dst_y_o     = dy_q;
  assign unit_width  = wu_q;
  assign x_fwd       = xf_q;
  assign y_fwd       = yf_q;
  assign rot_code    = rot_q;
  assign rot_en      = en_q;
  assign src_xy_word = {sx_q[15:0], sy_q[15:0]};
  assign dst_xy_word = {dx_q[15:0], dy_q[15:0]};
  assign size_word   = {wu_q[15:0], h_q[15:0]};
  assign busy        = walk_act;
  assign walk_valid  = walk_act;

  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rs_n)
    (req_valid && req_ready && !nonempty) |=> (!setup_valid && !walk_valid)); // R1
  AST_SETUP_ONE: assert property (@(posedge clk) disable iff (!rs_n)
    setup_valid |=> !setup_valid); // R8
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && $past(busy)) |-> ($stable(dst_x_o) && $stable(dst_y_o) && $stable(size_word))); // R8
  AST_ROT_RANGE: assert property (@(posedge clk) disable iff (!rs_n)
    setup_valid |-> (rot_code < 3'd6)); // R5
  AST_ROT_OFF: assert property (@(posedge clk) disable iff (!rs_n)
    (setup_valid && !rot_en) |-> (rot_code == 3'd0)); // R5
endmodule

// File: tb/blit_setup_bench.sv
module blit_setup_bench;
  localparam int CW = 16;
  localparam int XW = CW + 3;
  localparam int YW = CW + 1;
  localparam time TCLK = 10ns;
  localparam int WDOG = 150000;

  logic clk, rst_n;
  logic req_valid, req_ready, req_mode24;
  logic [CW-1:0] req_src_x, req_src_y, req_dst_x, req_dst_y, req_width, req_height;
  logic setup_valid, x_fwd, y_fwd, rot_en, busy, walk_valid, walk_last;
  logic [XW-1:0] src_x_o, dst_x_o, unit_width, walk_x;
  logic [YW-1:0] src_y_o, dst_y_o, walk_y;
  logic [2:0] rot_code;
  logic [15:0] dir_word;
  logic [31:0] src_xy_word, dst_xy_word, size_word;

  int vec_n, bad_n;
  bit done;

  blit_setup #(.CW(CW)) u_blit_setup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_x(req_src_x), .req_src_y(req_src_y), .req_dst_x(req_dst_x),
    .req_dst_y(req_dst_y), .req_width(req_width), .req_height(req_height),
    .req_mode24(req_mode24), .setup_valid(setup_valid), .src_x_o(src_x_o),
    .src_y_o(src_y_o), .dst_x_o(dst_x_o), .dst_y_o(dst_y_o),
    .unit_width(unit_width), .x_fwd(x_fwd), .y_fwd(y_fwd), .rot_code(rot_code),
    .rot_en(rot_en), .dir_word(dir_word), .src_xy_word(src_xy_word),
    .dst_xy_word(dst_xy_word), .size_word(size_word), .busy(busy),
    .walk_valid(walk_valid), .walk_x(walk_x), .walk_y(walk_y), .walk_last(walk_last)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    vec_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input int m, input int sx, input int sy, input int dx,
                         input int dy, input int w, input int h);
    longint s3, d3, w3, esx, esy, edx, edy, rot, dirw;
    int xf, yf;
    @(negedge clk);
    chk("R8 ready when idle", req_ready, 1);
    req_mode24 = m[0];
    req_src_x = CW'(sx); req_src_y = CW'(sy);
    req_dst_x = CW'(dx); req_dst_y = CW'(dy);
    req_width = CW'(w);  req_height = CW'(h);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (w == 0 || h == 0) begin
      chk("R1 no setup", setup_valid, 0);
      chk("R1 no walk", walk_valid, 0);
      chk("R1 still ready", req_ready, 1);
      return;
    end
    s3 = m ? 3*sx : sx;
    d3 = m ? 3*dx : dx;
    w3 = m ? 3*w : w;
    yf = (sy < dy) ? 0 : 1;
    xf = (s3 < d3) ? 0 : 1;
    esy = yf ? sy : sy + h - 1;
    edy = yf ? dy : dy + h - 1;
    esx = xf ? s3 : s3 + w3 - 1;
    edx = xf ? d3 : d3 + w3 - 1;
    rot = m ? (((edx + (xf ? 0 : 2)) / 4) % 6) : 0;
    dirw = xf | (yf << 1) | (1 << 5) | (m << 7) | (rot << 8);
    chk("R8 setup pulse", setup_valid, 1);
    chk("R2 unit width", unit_width, w3);
    chk("R4 src x", src_x_o, esx);
    chk("R4 dst x", dst_x_o, edx);
    chk("R4 x dir", x_fwd, xf);
    chk("R3 src y", src_y_o, esy);
    chk("R3 dst y", dst_y_o, edy);
    chk("R3 y dir", y_fwd, yf);
    chk("R5 rot code", rot_code, rot);
    chk("R5 rot en", rot_en, m);
    chk("R7 dir word", dir_word, dirw);
    chk("R6 src word", src_xy_word, ((esx & 16'hffff) << 16) | (esy & 16'hffff));
    chk("R6 dst word", dst_xy_word, ((edx & 16'hffff) << 16) | (edy & 16'hffff));
    chk("R6 size word", size_word, ((w3 & 16'hffff) << 16) | (h & 16'hffff));
    for (int r = 0; r < h; r++) begin
      for (longint c = 0; c < w3; c++) begin
        if (!(r == 0 && c == 0)) @(negedge clk);
        chk("R9 walk valid", walk_valid, 1);
        chk("R9 walk x", walk_x, xf ? edx + c : edx - c);
        chk("R9 walk y", walk_y, yf ? edy + r : edy - r);
        chk("R9 walk last", walk_last, (r == h-1 && c == w3-1) ? 1 : 0);
        chk("R8 busy", busy, 1);
        chk("R8 not ready", req_ready, 0);
        if (!(r == 0 && c == 0)) chk("R8 setup once", setup_valid, 0);
      end
    end
    @(negedge clk);
    chk("R9 walk done", walk_valid, 0);
    chk("R8 idle after", busy, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      bad_n++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end

  initial begin
    vec_n = 0; bad_n = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_mode24 = 1'b0;
    req_src_x = '0; req_src_y = '0; req_dst_x = '0; req_dst_y = '0;
    req_width = '0; req_height = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset setup", setup_valid, 0);
    chk("R9 reset walk", walk_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset ready", req_ready, 1);
    chk("R8 reset busy", busy, 0);

    // Sweep over small geometry in both modes, including empty sizes
    for (int m = 0; m < 2; m++)
      for (int sx = 0; sx < 4; sx++)
        for (int dx = 0; dx < 4; dx++)
          for (int sy = 0; sy < 3; sy++)
            for (int dy = 0; dy < 3; dy++)
              for (int w = 0; w < 3; w++)
                for (int h = 0; h < 3; h++)
                  run_req(m, sx + 5, sy + 2, dx + 5, dy + 2, w, h);

    // Rotation phase across many destination x in both directions (R5)
    for (int dx = 0; dx < 30; dx++) begin
      run_req(1, dx + 1, 0, dx, 0, 1, 1);
      run_req(1, dx, 0, dx + 1, 0, 2, 1);
    end

    // Wide coordinates: scaling does not wrap before packing (R2, R6)
    run_req(1, 65535, 7, 65534, 9, 2, 2);
    run_req(1, 65530, 65535, 65533, 65530, 3, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule